// File: doc/BRIEF.md
# Smart Card T=0 Character Receiver

This block takes the asynchronous I/O line of a smart card and turns each character into a byte. All timing is measured in elementary time units (ETU). The length of one ETU is set in clocks by the `etu_clks` input. The line passes through a two-flop synchroniser. A falling edge on the synchronised line opens a character frame. The start bit and each following bit are sampled at the middle of their ETU. The block keeps a half-ETU timebase, so every event in the frame falls on a half-ETU boundary.

Software can arm the receiver so that the next character is treated as the initial TS character. That character then selects the coding convention: direct, or inverse. The choice is held in a status bit that software can also overwrite. Every character is decoded under the current convention and its parity is checked. In T=0 mode a parity error can make the block pull the line low for a selectable break length, starting halfway through the guard time. A character that drew a break is not passed on, because the card will send it again. Any other character is presented on a valid/ready output toward a receive FIFO.

The block also exports a one-cycle strobe at 11 ETU into each frame. Transmit logic can use this strobe to sample a break returned by the card.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, `ts_armed` is 0, `conv_direct` is 1 (direct convention), `m_valid` is 0, and `io_drive_low` is 0.
- R2: A frame opens on a high-to-low transition of the synchronised line. A line that is back high at the middle of the start bit cancels the frame: no byte, no flag, no strobe.
- R3: With `ts_armed` set, raw line bits (first received bit in bit 0) equal to 0x3B select direct convention (`conv_direct`=1) and deliver 0x3B. Raw bits equal to 0x03 select inverse convention (`conv_direct`=0) and deliver 0x3F.
- R4: With `ts_armed` set, any other raw pattern pulses `ts_err` for one cycle and leaves `conv_direct` unchanged. `ts_armed` is still cleared, and the byte is decoded under the existing convention.
- R5: When `ts_armed` is clear, a character never changes `conv_direct`.
- R6: In direct convention the first data bit is bit 0, a high line is a 1, and the eight data bits plus the parity bit hold an even number of high levels.
- R7: In inverse convention the first data bit is bit 7, a low line is a 1, and the eight logical data bits plus the logical parity bit hold an even number of ones.
- R8: If `parity_dis` is 0, a parity mismatch pulses `parity_err` for one cycle, 9.5 ETU after the start edge plus 2 clocks. If `parity_dis` is 1, no mismatch is reported.
- R9: A reported mismatch with `t0_mode`=1 and `brk_en`=1 drives `io_drive_low` from 10.5 ETU after the start edge plus 2 clocks. The length is set by `brk_sel`: 00 gives 1 ETU, 01 gives 1.5 ETU, 10 gives 2 ETU, and 11 gives 1 ETU. That character is not delivered.
- R10: `io_drive_low` is never 1 except in such a break window. With `brk_en`=0 or `t0_mode`=0 no break is driven and the byte is delivered.
- R11: `guard_strobe` pulses once per frame that passed its start check, 11 ETU after the start edge plus 2 clocks.
- R12: A decoded byte raises `m_valid` together with `m_data`. Both hold until `m_ready` is seen high. A later character replaces an unaccepted byte.
- R13: `ts_arm_set` sets `ts_armed` on the next clock. `conv_wr` loads `conv_wdata` into `conv_direct` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_clks | input | ETU_W | Clocks per ETU (even, at least 4) |
| t0_mode | input | 1 | T=0 protocol selected; enables error breaks |
| parity_dis | input | 1 | Disable parity checking |
| brk_en | input | 1 | Enable error break generation |
| brk_sel | input | 2 | Break length code |
| ts_arm_set | input | 1 | Pulse: treat next character as TS |
| conv_wr | input | 1 | Pulse: write the convention bit |
| conv_wdata | input | 1 | Convention value to write (1 = direct) |
| ts_armed | output | 1 | Next character will be treated as TS |
| conv_direct | output | 1 | Current convention (1 = direct, 0 = inverse) |
| io_in | input | 1 | Card I/O line level |
| io_drive_low | output | 1 | Pull the I/O line low (open-drain) |
| m_valid | output | 1 | Decoded byte available |
| m_data | output | 8 | Decoded byte |
| m_ready | input | 1 | Consumer accepts the byte |
| parity_err | output | 1 | One-cycle parity error pulse |
| ts_err | output | 1 | One-cycle pulse: armed TS matched no pattern |
| guard_strobe | output | 1 | One-cycle pulse at 11 ETU into the frame |

## Verification
Every frame result is due a fixed number of half-ETUs after the start edge, plus two clocks for the synchroniser. A byte, `parity_err` and `ts_err` are due after 19 half-ETUs. The break begins after 21 half-ETUs and ends 2, 3 or 4 half-ETUs later. The strobe comes after 22 half-ETUs. The reference model stamps each character with the cycle on which its start bit was driven. It derives every expected output from the offset to that stamp, and compares all outputs at each falling clock edge, half a cycle away from the edge that updates them. Software writes and handshakes are modelled as taking effect at the rising edge that samples them.

// File: rtl/sc_t0_rx.sv
module sc_t0_rx #(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_clks,
  input  logic             t0_mode,
  input  logic             parity_dis,
  input  logic             brk_en,
  input  logic [1:0]       brk_sel,
  input  logic             ts_arm_set,
  input  logic             conv_wr,
  input  logic             conv_wdata,
  output logic             ts_armed,
  output logic             conv_direct,
  input  logic             io_in,
  output logic             io_drive_low,
  output logic             m_valid,
  output logic [7:0]       m_data,
  input  logic             m_ready,
  output logic             parity_err,
  output logic             ts_err,
  output logic             guard_strobe
);

  localparam int HX_W       = 5;
  localparam int H_PARITY   = 18;
  localparam int H_BRK_ON   = 20;
  localparam int H_STROBE   = 21;
  localparam int H_LAST     = 24;
  localparam logic [7:0] TS_DIRECT_RAW  = 8'h3B;
  localparam logic [7:0] TS_INVERSE_RAW = 8'h03;

  logic             io_s, io_p;
  logic             busy;
  logic [ETU_W-1:0] hcnt;
  logic [HX_W-1:0]  hidx;
  logic [7:0]       raw;
  logic             brk_pend;
  logic [2:0]       brk_len;
  logic [7:0]       inv_byte;

  wire [ETU_W-1:0] half_clks = {1'b0, etu_clks[ETU_W-1:1]};
  wire tick       = busy && (hcnt == half_clks - 1'b1);
  wire start_fail = tick && (hidx == '0) && io_s;
  wire shift_bit  = tick && !hidx[0] && (hidx >= HX_W'(2)) && (hidx <= HX_W'(16));
  wire done       = tick && (hidx == HX_W'(H_PARITY));

  wire ts_dir   = ts_armed && (raw == TS_DIRECT_RAW);
  wire ts_inv   = ts_armed && (raw == TS_INVERSE_RAW);
  wire use_dir  = ts_dir ? 1'b1 : (ts_inv ? 1'b0 : conv_direct);
  wire par_bad  = !parity_dis && ((^{raw, io_s}) ^ !use_dir);
  wire brk_go   = par_bad && t0_mode && brk_en;
  wire [2:0] sel_len = (brk_sel == 2'b01) ? 3'd3 : (brk_sel == 2'b10) ? 3'd4 : 3'd2;
  wire [HX_W-1:0] h_release = HX_W'(H_BRK_ON) + {2'b00, brk_len};

  always_comb
    for (int i = 0; i < 8; i++) inv_byte[7-i] = ~raw[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_s <= 1'b1;
      io_p <= 1'b1;
    end else begin
      io_s <= io_in;
      io_p <= io_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      hidx <= '0;
    end else if (!busy) begin
      if (io_p && !io_s) begin
        busy <= 1'b1;
        hcnt <= '0;
        hidx <= '0;
      end
    end else if (tick) begin
      hcnt <= '0;
      hidx <= hidx + 1'b1;
      if (start_fail || hidx == HX_W'(H_LAST)) busy <= 1'b0;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else if (shift_bit) raw <= {io_s, raw[7:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pend     <= 1'b0;
      brk_len      <= 3'd2;
      io_drive_low <= 1'b0;
    end else begin
      if (done) begin
        brk_pend <= brk_go;
        brk_len  <= sel_len;
      end
      if (tick && hidx == HX_W'(H_BRK_ON)) io_drive_low <= brk_pend;
      else if (tick && (hidx == h_release || hidx == HX_W'(H_LAST))) io_drive_low <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity_err   <= 1'b0;
      ts_err       <= 1'b0;
      guard_strobe <= 1'b0;
      m_valid      <= 1'b0;
      m_data       <= '0;
    end else begin
      parity_err   <= done && par_bad;
      ts_err       <= done && ts_armed && !ts_dir && !ts_inv;
      guard_strobe <= tick && (hidx == HX_W'(H_STROBE));
      if (done && !brk_go) begin
        m_valid <= 1'b1;
        m_data  <= use_dir ? raw : inv_byte;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_armed    <= 1'b0;
      conv_direct <= 1'b1;
    end else begin
      if (ts_arm_set) ts_armed <= 1'b1;
      else if (done)  ts_armed <= 1'b0;
      if (conv_wr)     conv_direct <= conv_wdata;
      else if (ts_dir && done) conv_direct <= 1'b1;
      else if (ts_inv && done) conv_direct <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_t0_rx_chk.sv
module sc_t0_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       io_drive_low,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       parity_err,
  input logic       parity_dis,
  input logic       ts_err,
  input logic       ts_armed,
  input logic       ts_arm_set,
  input logic       conv_direct,
  input logic       conv_wr,
  input logic       guard_strobe
);

  assert_break_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive_low |-> busy);

  assert_hold_until_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !done) |=> (m_valid && $stable(m_data)));

  assert_parity_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> !$past(parity_dis));

  assert_bad_ts_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_err && !$past(ts_arm_set)) |-> !ts_armed);

  assert_bad_ts_keeps_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_err && !$past(conv_wr)) |-> $stable(conv_direct));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    guard_strobe |=> !guard_strobe);

endmodule

bind sc_t0_rx sc_t0_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .io_drive_low(io_drive_low), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .parity_err(parity_err), .parity_dis(parity_dis),
  .ts_err(ts_err), .ts_armed(ts_armed), .ts_arm_set(ts_arm_set),
  .conv_direct(conv_direct), .conv_wr(conv_wr), .guard_strobe(guard_strobe)
);

// File: tb/sc_t0_rx_tb.sv
module sc_t0_rx_tb;
  localparam int H = 8;
  localparam int EV_DATA = 2 + 19*H;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [11:0] etu_clks = 12'(2*H);
  logic t0_mode = 1'b1, parity_dis = 1'b0, brk_en = 1'b1;
  logic [1:0] brk_sel = 2'b00;
  logic ts_arm_set = 1'b0, conv_wr = 1'b0, conv_wdata = 1'b0;
  logic ts_armed, conv_direct, io_drive_low, m_valid, parity_err, ts_err, guard_strobe;
  logic [7:0] m_data;
  logic m_ready = 1'b0;
  logic card = 1'b1;
  wire io_in = card & ~io_drive_low;

  sc_t0_rx #(.ETU_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .etu_clks(etu_clks), .t0_mode(t0_mode),
    .parity_dis(parity_dis), .brk_en(brk_en), .brk_sel(brk_sel),
    .ts_arm_set(ts_arm_set), .conv_wr(conv_wr), .conv_wdata(conv_wdata),
    .ts_armed(ts_armed), .conv_direct(conv_direct), .io_in(io_in),
    .io_drive_low(io_drive_low), .m_valid(m_valid), .m_data(m_data),
    .m_ready(m_ready), .parity_err(parity_err), .ts_err(ts_err),
    .guard_strobe(guard_strobe));

  int checks = 0, errors = 0;
  int cyc = 0, c0 = -100000;
  bit act = 0, started = 0;
  bit x_deliver, x_perr, x_tserr, x_clr, x_cset, x_cval;
  logic [7:0] x_byte;
  int x_n = 0;
  logic e_valid, e_perr, e_tserr, e_drv, e_strobe, e_armed, e_conv;
  logic [7:0] e_data;
  int strobes = 0, perrs = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, a, e);
    end
  endtask

  always @(posedge clk) begin
    int off;
    off = cyc + 1 - c0;
    cyc <= cyc + 1;
    if (!rst_n) begin
      e_valid <= 0; e_data <= 0; e_perr <= 0; e_tserr <= 0; e_drv <= 0;
      e_strobe <= 0; e_armed <= 0; e_conv <= 1;
    end else begin
      e_perr   <= act && off == EV_DATA && x_perr;
      e_tserr  <= act && off == EV_DATA && x_tserr;
      e_strobe <= act && off == 2 + 22*H;
      e_drv    <= act && x_n > 0 && off >= 2 + 21*H && off < 2 + (21 + x_n)*H;
      if (act && off == EV_DATA && x_deliver) begin
        e_valid <= 1; e_data <= x_byte;
      end else if (m_ready) e_valid <= 0;
      if (ts_arm_set) e_armed <= 1;
      else if (act && off == EV_DATA && x_clr) e_armed <= 0;
      if (conv_wr) e_conv <= conv_wdata;
      else if (act && off == EV_DATA && x_cset) e_conv <= x_cval;
    end
  end

  always @(negedge clk) if (started) begin
    chk(m_valid === e_valid, "R12 m_valid", m_valid, e_valid);
    if (e_valid) chk(m_data === e_data, "R12 m_data", m_data, e_data);
    chk(parity_err === e_perr, "R8 parity_err", parity_err, e_perr);
    chk(ts_err === e_tserr, "R4 ts_err", ts_err, e_tserr);
    chk(io_drive_low === e_drv, "R9 io_drive_low", io_drive_low, e_drv);
    chk(guard_strobe === e_strobe, "R11 guard_strobe", guard_strobe, e_strobe);
    chk(ts_armed === e_armed, "R13 ts_armed", ts_armed, e_armed);
    chk(conv_direct === e_conv, "R3 conv_direct", conv_direct, e_conv);
    if (guard_strobe) strobes++;
    if (parity_err) perrs++;
  end

  function automatic logic [8:0] enc_dir(input logic [7:0] b, input bit bad);
    return {(^b) ^ bad, b};
  endfunction

  function automatic logic [8:0] enc_inv(input logic [7:0] b, input bit bad);
    logic [8:0] l;
    for (int i = 0; i < 8; i++) l[i] = ~b[7-i];
    l[8] = ~(^b) ^ bad;
    return l;
  endfunction

  task automatic send(input logic [8:0] lb);
    bit conv, bad;
    int ones;
    conv = e_conv;
    x_clr = e_armed; x_cset = 0; x_cval = 0; x_tserr = 0;
    if (e_armed) begin
      if (lb[7:0] == 8'h3B) begin conv = 1; x_cset = 1; x_cval = 1; end
      else if (lb[7:0] == 8'h03) begin conv = 0; x_cset = 1; x_cval = 0; end
      else x_tserr = 1;
    end
    if (conv) x_byte = lb[7:0];
    else for (int i = 0; i < 8; i++) x_byte[7-i] = ~lb[i];
    ones = $countones(lb);
    bad = conv ? (ones % 2 == 1) : ((9 - ones) % 2 == 1);
    x_perr = bad && !parity_dis;
    x_n = (x_perr && t0_mode && brk_en) ? (brk_sel == 2'b01 ? 3 : brk_sel == 2'b10 ? 4 : 2) : 0;
    x_deliver = (x_n == 0);
    @(negedge clk);
    c0 = cyc; act = 1; card = 1'b0;
    repeat (2*H) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      card = lb[i];
      repeat (2*H) @(negedge clk);
    end
    card = 1'b1;
    repeat (16*H) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk) m_ready = 1'b1;
    @(negedge clk) m_ready = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk) ts_arm_set = 1'b1;
    @(negedge clk) ts_arm_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int s0, p0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    chk(ts_armed === 0 && conv_direct === 1, "R1 reset flags", {ts_armed, conv_direct}, 2'b01);
    chk(m_valid === 0 && io_drive_low === 0, "R1 reset outputs", {m_valid, io_drive_low}, 0);

    send(enc_dir(8'hA5, 0));
    chk(m_valid && m_data === 8'hA5, "R6 direct byte", m_data, 8'hA5);
    chk(conv_direct === 1, "R5 unarmed keeps conv", conv_direct, 1);
    accept();

    arm();
    chk(ts_armed === 1, "R13 arm set", ts_armed, 1);
    send(enc_inv(8'h3F, 0));
    chk(conv_direct === 0 && m_data === 8'h3F, "R3 inverse TS", {conv_direct, m_data}, 9'h03F);
    chk(ts_armed === 0, "R3 arm cleared", ts_armed, 0);
    accept();

    send(enc_inv(8'h5C, 0));
    chk(m_valid && m_data === 8'h5C, "R7 inverse byte", m_data, 8'h5C);
    accept();

    for (int s = 0; s < 4; s++) begin
      brk_sel = 2'(s);
      p0 = perrs;
      send(enc_inv(8'hC3 ^ 8'(s), 1));
      chk(m_valid === 0, "R9 break withholds byte", m_valid, 0);
      chk(perrs == p0 + 1, "R8 parity error seen", perrs - p0, 1);
    end
    brk_sel = 2'b00;

    @(negedge clk) begin conv_wr = 1'b1; conv_wdata = 1'b1; end
    @(negedge clk) conv_wr = 1'b0;
    chk(conv_direct === 1, "R13 conv write", conv_direct, 1);

    arm();
    send(enc_dir(8'h3B, 0));
    chk(conv_direct === 1 && m_data === 8'h3B, "R3 direct TS", {conv_direct, m_data}, 9'h13B);
    accept();

    brk_en = 1'b0;
    send(enc_dir(8'h7E, 1));
    chk(m_valid && m_data === 8'h7E, "R10 no break when disabled", m_data, 8'h7E);
    accept();
    brk_en = 1'b1; t0_mode = 1'b0;
    send(enc_dir(8'h81, 1));
    chk(m_valid && m_data === 8'h81, "R10 no break outside T=0", m_data, 8'h81);
    accept();
    t0_mode = 1'b1; parity_dis = 1'b1;
    p0 = perrs;
    send(enc_dir(8'h42, 1));
    chk(perrs == p0 && m_data === 8'h42, "R8 parity disabled", perrs - p0, 0);
    accept();
    parity_dis = 1'b0;

    arm();
    send(enc_dir(8'h55, 0));
    chk(conv_direct === 1 && ts_armed === 0, "R4 bad TS", {conv_direct, ts_armed}, 2'b10);
    chk(m_data === 8'h55, "R4 bad TS byte", m_data, 8'h55);
    accept();

    s0 = strobes;
    act = 0;
    @(negedge clk) card = 1'b0;
    repeat (3) @(negedge clk);
    card = 1'b1;
    repeat (30*H) @(negedge clk);
    chk(strobes == s0 && m_valid === 0, "R2 glitch rejected", strobes - s0, 0);

    s0 = strobes;
    send(enc_dir(8'h12, 0));
    chk(strobes == s0 + 1, "R11 one strobe per frame", strobes - s0, 1);
    send(enc_dir(8'h34, 0));
    chk(m_valid && m_data === 8'h34, "R12 replaced byte", m_data, 8'h34);
    accept();
    chk(m_valid === 0, "R12 accepted", m_valid, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule